// File: doc/BRIEF.md
# Two-Input Up/Down Event Counter

This block keeps a 16-bit signed-agnostic event tally that two asynchronous external lines move up and down. Both lines are brought into the fast system clock domain through a chain of flops. Edges are then found by comparing the newest synchronised sample with the one before it. Each line has its own edge select, so it can react to rising, falling or both edges, or be ignored.

A 3-bit mode input picks how edges become count steps. In pulse mode, a qualifying edge on line A adds one and a qualifying edge on line B subtracts one. When both arrive in the same clock cycle, they cancel and the count holds. In quadrature mode, the two lines carry signals a quarter period apart. Only line A edges step the count, and the synchronised level of line B taken in that same cycle picks the direction. A synchronous clear and a count enable complete the control set.

Top module: `updn_event_ctr`

## Requirements
- R1: While rst_ni is low, count_o is 0x0000, and no stale edge is detected after reset is released with both lines low.
- R2: A change on evt_a_i or evt_b_i driven between clock edges changes count_o at the third rising clock edge after it, and not earlier. This covers two synchroniser flops plus one count register.
- R3: The edge select encoding is the same for both lines: 2'b00 means no edge counts, 2'b01 means rising, 2'b10 means falling, and 2'b11 means both.
- R4: With mode_i = 3'b101, a qualifying edge on evt_a_i adds one to the count, and a qualifying edge on evt_b_i subtracts one.
- R5: With mode_i = 3'b101, qualifying edges on both lines in the same cycle leave the count unchanged.
- R6: With mode_i = 3'b110, only qualifying edges of evt_a_i step the count. The synchronised level of evt_b_i in the same cycle sets the direction: high adds one, low subtracts one. Edges of evt_b_i alone never change the count.
- R7: The count wraps in both directions: 0xFFFF plus one gives 0x0000, and 0x0000 minus one gives 0xFFFF.
- R8: Any mode_i value other than 3'b101 and 3'b110 holds the count, whatever the lines do.
- R9: clr_i high at a rising edge sets the count to 0x0000, even when a step would otherwise happen in that cycle.
- R10: While en_i is low, qualifying edges are dropped, not deferred, and the count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Count enable |
| clr_i | input | 1 | Synchronous clear, above counting in priority |
| mode_i | input | 3 | Counting mode (3'b101 pulse, 3'b110 quadrature, others hold) |
| sel_a_i | input | 2 | Edge select for line A |
| sel_b_i | input | 2 | Edge select for line B |
| evt_a_i | input | 1 | Asynchronous event line A (up line, or stepping line in quadrature) |
| evt_b_i | input | 1 | Asynchronous event line B (down line, or direction line in quadrature) |
| count_o | output | 16 | Current count value |

## Verification
The hardest case to reach is two edges that land in one detection cycle, because each line passes through its own synchroniser. The cancelling case only happens if both lines toggle between the same pair of clock edges. The bench drives both lines at the same falling clock edge for the directed cancel case. The random phase toggles each line independently on every cycle, so coincident edges, quadrature direction reversals and clears that collide with a pending step all occur many times. A cycle model in the bench follows the required pipeline depth and checks every cycle.

// File: rtl/updn_pkg.sv
package updn_pkg;

   typedef enum logic [1:0] {
      EDGE_OFF  = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_ANY  = 2'b11
   } edge_sel_e;

   typedef enum logic [1:0] {
      STEP_HOLD = 2'b00,
      STEP_INC  = 2'b01,
      STEP_DEC  = 2'b10
   } step_e;

   localparam int unsigned MODE_W_DEF     = 3;
   localparam logic [2:0]  MODE_PULSE_DEF = 3'b101;
   localparam logic [2:0]  MODE_QUAD_DEF  = 3'b110;

endpackage

// File: rtl/updn_sync_edge.sv
module updn_sync_edge
   import updn_pkg::*;
#(
   parameter int unsigned STAGES = 2
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       raw_i,
   input  logic [1:0] sel_i,
   output logic       level_o,
   output logic       edge_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("updn_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;
   logic              rise, fall;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], raw_i};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign level_o = chain_q[STAGES-1];
   assign rise    = level_o & ~prev_q;
   assign fall    = ~level_o & prev_q;

   always_comb begin
      unique case (edge_sel_e'(sel_i))
         EDGE_RISE: edge_o = rise;
         EDGE_FALL: edge_o = fall;
         EDGE_ANY:  edge_o = rise | fall;
         default:   edge_o = 1'b0;
      endcase
   end

   // R3
   edge_needs_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      edge_o |-> (level_o != $past(level_o)));

endmodule

// File: rtl/updn_step_dec.sv
module updn_step_dec
   import updn_pkg::*;
#(
   parameter int unsigned       MODE_W     = MODE_W_DEF,
   parameter logic [MODE_W-1:0] MODE_PULSE = MODE_PULSE_DEF,
   parameter logic [MODE_W-1:0] MODE_QUAD  = MODE_QUAD_DEF
) (
   input  logic [MODE_W-1:0] mode_i,
   input  logic              edge_a_i,
   input  logic              edge_b_i,
   input  logic              lvl_b_i,
   output step_e             step_o
);

   if (MODE_PULSE == MODE_QUAD) begin : g_bad_modes
      $error("updn_step_dec: mode codes must differ");
   end

   step_e pulse_step, quad_step;

   always_comb begin
      unique case ({edge_a_i, edge_b_i})
         2'b10:   pulse_step = STEP_INC;
         2'b01:   pulse_step = STEP_DEC;
         default: pulse_step = STEP_HOLD;
      endcase
   end

   always_comb begin
      if (!edge_a_i)    quad_step = STEP_HOLD;
      else if (lvl_b_i) quad_step = STEP_INC;
      else              quad_step = STEP_DEC;
   end

   always_comb begin
      if (mode_i == MODE_PULSE)     step_o = pulse_step;
      else if (mode_i == MODE_QUAD) step_o = quad_step;
      else                          step_o = STEP_HOLD;
   end

endmodule

// File: rtl/updn_count_reg.sv
module updn_count_reg
   import updn_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic             en_i,
   input  step_e            step_i,
   output logic [CNT_W-1:0] cnt_o
);

   if (CNT_W < 2) begin : g_bad_width
      $error("updn_count_reg: CNT_W must be at least 2");
   end

   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] FULL = '1;

   logic [CNT_W-1:0] cnt_q, cnt_d;

   always_comb begin
      cnt_d = cnt_q;
      if (clr_i) begin
         cnt_d = '0;
      end else if (en_i) begin
         unique case (step_i)
            STEP_INC: cnt_d = cnt_q + ONE;
            STEP_DEC: cnt_d = cnt_q - ONE;
            default:  cnt_d = cnt_q;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else         cnt_q <= cnt_d;
   end

   assign cnt_o = cnt_q;

   // R9
   clear_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (cnt_q == '0));

   // R10
   disabled_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_i && !clr_i) |=> $stable(cnt_q));

   // R7
   wrap_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i && en_i && step_i == STEP_INC && cnt_q == FULL) |=> (cnt_q == '0));

   // R7
   wrap_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i && en_i && step_i == STEP_DEC && cnt_q == '0) |=> (cnt_q == FULL));

endmodule

// File: rtl/updn_event_ctr.sv
module updn_event_ctr
   import updn_pkg::*;
#(
   parameter int unsigned       CNT_W       = 16,
   parameter int unsigned       SYNC_STAGES = 2,
   parameter int unsigned       MODE_W      = MODE_W_DEF,
   parameter logic [MODE_W-1:0] MODE_PULSE  = MODE_PULSE_DEF,
   parameter logic [MODE_W-1:0] MODE_QUAD   = MODE_QUAD_DEF
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              en_i,
   input  logic              clr_i,
   input  logic [MODE_W-1:0] mode_i,
   input  logic [1:0]        sel_a_i,
   input  logic [1:0]        sel_b_i,
   input  logic              evt_a_i,
   input  logic              evt_b_i,
   output logic [CNT_W-1:0]  count_o
);

   localparam int unsigned N_LINES = 2;
   localparam int unsigned IDX_A   = 0;
   localparam int unsigned IDX_B   = 1;

   logic [N_LINES-1:0]   raw_vec, lvl_vec, edge_vec;
   logic [2*N_LINES-1:0] sel_vec;
   logic                 unused_lvl_a;
   step_e                step;

   assign raw_vec      = {evt_b_i, evt_a_i};
   assign sel_vec      = {sel_b_i, sel_a_i};
   assign unused_lvl_a = lvl_vec[IDX_A];

   for (genvar li = 0; li < N_LINES; li++) begin : g_line
      updn_sync_edge #(
         .STAGES (SYNC_STAGES)
      ) u_sync (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .raw_i   (raw_vec[li]),
         .sel_i   (sel_vec[2*li +: 2]),
         .level_o (lvl_vec[li]),
         .edge_o  (edge_vec[li])
      );
   end

   updn_step_dec #(
      .MODE_W     (MODE_W),
      .MODE_PULSE (MODE_PULSE),
      .MODE_QUAD  (MODE_QUAD)
   ) u_dec (
      .mode_i   (mode_i),
      .edge_a_i (edge_vec[IDX_A]),
      .edge_b_i (edge_vec[IDX_B]),
      .lvl_b_i  (lvl_vec[IDX_B]),
      .step_o   (step)
   );

   updn_count_reg #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr_i),
      .en_i   (en_i),
      .step_i (step),
      .cnt_o  (count_o)
   );

   // R5
   cancel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == MODE_PULSE && edge_vec[IDX_A] && edge_vec[IDX_B] && !clr_i)
      |=> $stable(count_o));

   // R4
   single_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == MODE_PULSE && en_i && !clr_i && edge_vec[IDX_A] && !edge_vec[IDX_B])
      |=> (count_o == $past(count_o) + CNT_W'(1)));

   // R6
   quad_b_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == MODE_QUAD && !edge_vec[IDX_A] && !clr_i) |=> $stable(count_o));

   // R6
   quad_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == MODE_QUAD && en_i && !clr_i && edge_vec[IDX_A] && !lvl_vec[IDX_B])
      |=> (count_o == $past(count_o) - CNT_W'(1)));

   // R8
   other_mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i != MODE_PULSE && mode_i != MODE_QUAD && !clr_i) |=> $stable(count_o));

endmodule

// File: tb/updn_event_ctr_tb.sv
module updn_event_ctr_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b1, clr = 1'b0;
   logic [2:0]  mode = 3'b101;
   logic [1:0]  sel_a = 2'b01, sel_b = 2'b01;
   logic        ea = 1'b0, eb = 1'b0;
   logic [15:0] count;

   int    checks = 0;
   int    errors = 0;
   bit    model_on = 1'b0;
   string cur_req = "R1";

   always #4 clk = ~clk;

   updn_event_ctr u_dut (
      .clk_i   (clk),
      .rst_ni  (rst_n),
      .en_i    (en),
      .clr_i   (clr),
      .mode_i  (mode),
      .sel_a_i (sel_a),
      .sel_b_i (sel_b),
      .evt_a_i (ea),
      .evt_b_i (eb),
      .count_o (count)
   );

   // reference model built from the requirements (R2 depth, R3 encoding)
   logic        ma1, ma2, map, mb1, mb2, mbp;
   logic [15:0] m_cnt;

   function automatic bit hit(logic [1:0] sel, logic cur, logic prv);
      case (sel)
         2'b01:   return cur & ~prv;
         2'b10:   return ~cur & prv;
         2'b11:   return cur ^ prv;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [15:0] next_cnt(logic [15:0] c, bit cl, bit en_v,
                                            logic [2:0] md, bit xa, bit xb, bit lb);
      if (cl)    return 16'h0000;
      if (!en_v) return c;
      if (md == 3'b101) begin
         if (xa && !xb) return c + 16'h1;
         if (xb && !xa) return c - 16'h1;
         return c;
      end
      if (md == 3'b110) begin
         if (!xa) return c;
         return lb ? c + 16'h1 : c - 16'h1;
      end
      return c;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         {ma1, ma2, map, mb1, mb2, mbp} <= '0;
         m_cnt <= 16'h0000;
      end else begin
         ma1 <= ea;  ma2 <= ma1; map <= ma2;
         mb1 <= eb;  mb2 <= mb1; mbp <= mb2;
         m_cnt <= next_cnt(m_cnt, clr, en, mode,
                           hit(sel_a, ma2, map), hit(sel_b, mb2, mbp), mb2);
      end
   end

   task automatic check(logic [15:0] act, logic [15:0] exp, string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: count actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (model_on && rst_n) check(count, m_cnt, cur_req);
   end

   task automatic tick(int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      process::self().srandom(32'd1234);
      tick(3);
      check(count, 16'h0000, "R1");
      rst_n = 1'b1;
      tick(3);
      check(count, 16'h0000, "R1");
      model_on = 1'b1;

      // R2 latency, R4 up step
      cur_req = "R2";
      ea = 1'b1; tick(2);
      check(count, 16'h0000, "R2");
      tick(1);
      check(count, 16'h0001, "R2");
      cur_req = "R3";
      ea = 1'b0; tick(4);
      check(count, 16'h0001, "R3");
      cur_req = "R4";
      eb = 1'b1; tick(4);
      check(count, 16'h0000, "R4");
      eb = 1'b0; tick(4);
      // R7 wrap down then up
      cur_req = "R7";
      eb = 1'b1; tick(4);
      check(count, 16'hFFFF, "R7");
      ea = 1'b1; tick(4);
      check(count, 16'h0000, "R7");
      ea = 1'b0; eb = 1'b0; tick(4);
      // R5 coincident edges cancel
      cur_req = "R5";
      ea = 1'b1; eb = 1'b1; tick(4);
      check(count, 16'h0000, "R5");
      ea = 1'b0; eb = 1'b0; tick(4);
      // R3 falling, both, none
      cur_req = "R3";
      sel_a = 2'b10;
      ea = 1'b1; tick(4);
      check(count, 16'h0000, "R3");
      ea = 1'b0; tick(4);
      check(count, 16'h0001, "R3");
      sel_a = 2'b11;
      ea = 1'b1; tick(4);
      ea = 1'b0; tick(4);
      check(count, 16'h0003, "R3");
      sel_a = 2'b00;
      ea = 1'b1; tick(4);
      ea = 1'b0; tick(4);
      check(count, 16'h0003, "R3");
      sel_a = 2'b01;
      // R6 quadrature
      cur_req = "R6";
      mode = 3'b110;
      eb = 1'b1; tick(4);
      check(count, 16'h0003, "R6");
      ea = 1'b1; tick(4);
      check(count, 16'h0004, "R6");
      ea = 1'b0; tick(2);
      eb = 1'b0; tick(4);
      check(count, 16'h0004, "R6");
      ea = 1'b1; tick(4);
      check(count, 16'h0003, "R6");
      ea = 1'b0; tick(4);
      // R8 other modes
      cur_req = "R8";
      mode = 3'b000;
      ea = 1'b1; eb = 1'b0; tick(4);
      ea = 1'b0; eb = 1'b1; tick(4);
      check(count, 16'h0003, "R8");
      eb = 1'b0; tick(4);
      // R10 enable low drops edges
      cur_req = "R10";
      mode = 3'b101;
      en = 1'b0;
      ea = 1'b1; tick(4);
      en = 1'b1; tick(3);
      check(count, 16'h0003, "R10");
      ea = 1'b0; tick(4);
      // R9 clear collides with pending step
      cur_req = "R9";
      ea = 1'b1; tick(2);
      clr = 1'b1; tick(1);
      check(count, 16'h0000, "R9");
      clr = 1'b0; tick(2);
      check(count, 16'h0000, "R9");
      ea = 1'b0; tick(4);

      // constrained random phase, checked every cycle by the model
      for (int i = 0; i < 6000; i++) begin
         int r;
         r = $urandom_range(0, 9);
         mode = (r < 5) ? 3'b101 : (r < 9) ? 3'b110 : 3'($urandom_range(0, 7));
         if (mode == 3'b101)      cur_req = "R4";
         else if (mode == 3'b110) cur_req = "R6";
         else                     cur_req = "R8";
         if ($urandom_range(0, 31) == 0) begin
            sel_a = 2'($urandom_range(0, 3));
            sel_b = 2'($urandom_range(0, 3));
         end
         en  = ($urandom_range(0, 9) != 0);
         clr = ($urandom_range(0, 63) == 0);
         if ($urandom_range(0, 2) == 0) ea = ~ea;
         if ($urandom_range(0, 2) == 0) eb = ~eb;
         if (mode == 3'b110 && $urandom_range(0, 1) == 0) begin
            // stay in one phase for a while so quadrature runs coherent
            repeat (3) @(negedge clk);
         end
         @(negedge clk);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule